// File: doc/BRIEF.md
# Inclined-Scan Line Offset Generator

This block supplies the starting page offset for each image line of a column-organised queue store. A 1-D morphological unit keeps one queue per column. If every line begins on the same page, each queue follows a vertical column. If the starting page moves by one every few lines, all queues lean together, and the unit then filters along an inclined segment. The lean is a rational slope: a runtime `step` over a runtime `modulo`. For example, 15/26 gives an angle just under 30 degrees.

The generator holds an error accumulator. At every end-of-line strobe it runs one integer line-drawing step. The sum `error + step` is compared with `modulo` by a subtractor. The sign bit of the difference picks the next error value, and it also decides whether the offset moves. The direction select has three effects:
- In fall mode the offset counts up.
- In rise mode it counts down.
- In vertical mode the offset stays where it is.

The offset wraps around the number of queues, which is the image width plus the slope-segment width. A frame-start pulse returns both registers to zero.

Top module: `slope_offset_gen`

## Requirements
- R1: After reset, and in the cycle after `frame_start_i` is high, `offset_o` is 0 and the error accumulator is 0. `frame_start_i` takes priority over a coincident `eol_i`.
- R2: `offset_o` changes only on the clock edge that samples `eol_i` high. Without an end-of-line strobe it stays stable.
- R3: On each end-of-line strobe in fall or rise mode, the block forms `e = error + step_i`. If `e >= modulo_i`, the error becomes `e - modulo_i` and the offset moves by one. Otherwise the error becomes `e` and the offset holds. Starting from zero with `step_i <= modulo_i`, the offset therefore moves exactly `floor(k*step_i/modulo_i)` times in k lines.
- R4: `slope_mode_i` = 2'b01 (fall) makes every move an increment. `slope_mode_i` = 2'b10 (rise) makes every move a decrement.
- R5: `slope_mode_i` = 2'b00 or 2'b11 (vertical) freezes both the offset and the error accumulator across end-of-line strobes.
- R6: An increment from `nq_i - 1` wraps the offset to 0.
- R7: A decrement from 0 wraps the offset to `nq_i - 1`.
- R8: With `nq_i >= 1` held through a frame, `offset_o` is always less than `nq_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Clears offset and error at the start of a frame |
| eol_i | input | 1 | One-cycle end-of-line strobe |
| slope_mode_i | input | 2 | 01 fall (up), 10 rise (down), 00/11 vertical (hold) |
| step_i | input | ERR_W | Rise of the slope per `modulo_i` lines |
| modulo_i | input | ERR_W | Denominator of the slope ratio, nonzero |
| nq_i | input | OFS_W | Number of queues (image width + segment width), at least 1 |
| offset_o | output | OFS_W | Starting page offset for the next line |

## Verification
The embedded assertions check several properties on every cycle:
- the offset stays stable between strobes;
- the clear happens after a frame start;
- the error accumulator remains below the modulo;
- the offset stays within range;
- the offset moves by one step, or wraps, when a carry occurs.

They cannot show that the long-run number of moves matches the rational slope. They also cannot show that vertical mode truly freezes the accumulator rather than letting it run. Only the bench's multi-line scenarios reveal both: they compare final offsets against counts worked out from the step/modulo ratio, and they watch the first carry after a held line.

// File: rtl/slope_offset_pkg.sv
package slope_offset_pkg;

    localparam int DEF_ERR_W = 8;
    localparam int DEF_OFS_W = 11;

    typedef enum logic [1:0] {
        SLOPE_VERT     = 2'b00,
        SLOPE_FALL     = 2'b01,
        SLOPE_RISE     = 2'b10,
        SLOPE_VERT_ALT = 2'b11
    } slope_mode_e;

    typedef struct packed {
        logic advance;   // accumulate this line
        logic move;      // offset steps this line
        logic up;        // direction of the step
    } ofs_cmd_t;

    function automatic logic mode_active(input slope_mode_e m);
        return (m == SLOPE_FALL) || (m == SLOPE_RISE);
    endfunction

endpackage

// File: rtl/slope_err_acc.sv
module slope_err_acc #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             advance,
    input  logic [ERR_W-1:0] step,
    input  logic [ERR_W-1:0] modulo,
    output logic             carry,
    output logic [ERR_W-1:0] err_o
);
    localparam int SUM_W  = ERR_W + 1;
    localparam int DIFF_W = ERR_W + 2;

    logic [ERR_W-1:0]  err_q;
    logic [SUM_W-1:0]  sum;
    logic [DIFF_W-1:0] diff;
    logic [ERR_W-1:0]  err_next;

    always_comb begin
        sum      = {1'b0, err_q} + {1'b0, step};
        diff     = {1'b0, sum} - {2'b00, modulo};
        carry    = ~diff[DIFF_W-1];
        err_next = carry ? diff[ERR_W-1:0] : sum[ERR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            err_q <= '0;
        else if (advance)
            err_q <= err_next;
    end

    assign err_o = err_q;

    // R3
    err_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !clr && $stable(modulo) && step <= modulo && err_q < modulo)
        |=> err_q < modulo);

    // R1
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> err_q == '0);

    // R5
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clr) |=> $stable(err_q));

endmodule

// File: rtl/slope_ofs_ctr.sv
module slope_ofs_ctr
    import slope_offset_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  ofs_cmd_t         cmd,
    input  logic [OFS_W-1:0] nq,
    output logic [OFS_W-1:0] offset_o
);
    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] last_q;
    logic [OFS_W-1:0] ofs_next;

    always_comb begin
        last_q   = (nq == '0) ? '0 : nq - 1'b1;
        ofs_next = ofs_q;
        if (cmd.move) begin
            if (cmd.up)
                ofs_next = (ofs_q >= last_q) ? '0 : ofs_q + 1'b1;
            else
                ofs_next = (ofs_q == '0 || ofs_q > last_q) ? last_q : ofs_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            ofs_q <= '0;
        else
            ofs_q <= ofs_next;
    end

    assign offset_o = ofs_q;

    // R6
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cmd.move && cmd.up && nq != '0 && ofs_q == nq - 1'b1)
        |=> ofs_q == '0);

    // R7
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cmd.move && !cmd.up && nq != '0 && ofs_q == '0)
        |=> ofs_q == $past(nq) - 1'b1);

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cmd.move && cmd.up && nq != '0 && ofs_q + 1'b1 < nq)
        |=> ofs_q == $past(ofs_q) + 1'b1);

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cmd.move && !cmd.up && ofs_q != '0 && ofs_q < nq)
        |=> ofs_q == $past(ofs_q) - 1'b1);

endmodule

// File: rtl/slope_offset_gen.sv
module slope_offset_gen
    import slope_offset_pkg::*;
#(
    parameter int ERR_W = DEF_ERR_W,
    parameter int OFS_W = DEF_OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start_i,
    input  logic             eol_i,
    input  logic [1:0]       slope_mode_i,
    input  logic [ERR_W-1:0] step_i,
    input  logic [ERR_W-1:0] modulo_i,
    input  logic [OFS_W-1:0] nq_i,
    output logic [OFS_W-1:0] offset_o
);
    slope_mode_e      mode;
    ofs_cmd_t         cmd;
    logic             carry;
    logic [ERR_W-1:0] err_unused;

    assign mode = slope_mode_e'(slope_mode_i);

    always_comb begin
        cmd.advance = eol_i && mode_active(mode);
        cmd.move    = cmd.advance && carry;
        cmd.up      = (mode == SLOPE_FALL);
    end

    slope_err_acc #(.ERR_W(ERR_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (frame_start_i),
        .advance (cmd.advance),
        .step    (step_i),
        .modulo  (modulo_i),
        .carry   (carry),
        .err_o   (err_unused)
    );

    slope_ofs_ctr #(.OFS_W(OFS_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .clr      (frame_start_i),
        .cmd      (cmd),
        .nq       (nq_i),
        .offset_o (offset_o)
    );

    // R1
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start_i |=> offset_o == '0);

    // R2
    no_eol_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!eol_i && !frame_start_i) |=> $stable(offset_o));

    // R5
    vert_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_start_i && !mode_active(mode)) |=> $stable(offset_o));

    // R8
    in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_start_i && nq_i != '0 && $stable(nq_i)) |-> offset_o < nq_i);

endmodule

// File: tb/sim_slope_offset_gen.sv
`timescale 1ns/1ps
module sim_slope_offset_gen;
    localparam int ERR_W = 8;
    localparam int OFS_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             frame_start_i = 1'b0;
    logic             eol_i = 1'b0;
    logic [1:0]       slope_mode_i = 2'b00;
    logic [ERR_W-1:0] step_i = '0;
    logic [ERR_W-1:0] modulo_i = 8'd1;
    logic [OFS_W-1:0] nq_i = 11'd1;
    logic [OFS_W-1:0] offset_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    slope_offset_gen #(.ERR_W(ERR_W), .OFS_W(OFS_W)) u0 (
        .clk(clk), .rst(rst), .frame_start_i(frame_start_i), .eol_i(eol_i),
        .slope_mode_i(slope_mode_i), .step_i(step_i), .modulo_i(modulo_i),
        .nq_i(nq_i), .offset_o(offset_o)
    );

    typedef struct packed {
        logic [1:0]       mode;
        logic [ERR_W-1:0] step;
        logic [ERR_W-1:0] modv;
        logic [OFS_W-1:0] nq;
        logic [7:0]       lines;
        logic [OFS_W-1:0] expect_ofs;
    } vec_t;

    // expected = floor(lines*step/mod) moves, wrapped modulo nq in the mode's direction
    localparam vec_t VECS [0:7] = '{
        '{2'b01, 8'd15, 8'd26, 11'd40,  8'd26, 11'd15},  // R3 R4 fall
        '{2'b10, 8'd15, 8'd26, 11'd40,  8'd26, 11'd25},  // R4 R7 rise
        '{2'b00, 8'd15, 8'd26, 11'd40,  8'd26, 11'd0 },  // R5 vertical
        '{2'b01, 8'd1,  8'd1,  11'd5,   8'd7,  11'd2 },  // R6 wrap up
        '{2'b01, 8'd0,  8'd7,  11'd10,  8'd10, 11'd0 },  // R3 zero step
        '{2'b10, 8'd3,  8'd4,  11'd4,   8'd8,  11'd2 },  // R7 wrap down
        '{2'b01, 8'd7,  8'd10, 11'd100, 8'd13, 11'd9 },  // R3 partial period
        '{2'b11, 8'd5,  8'd6,  11'd9,   8'd4,  11'd0 }   // R5 alt vertical code
    };

    task automatic check(input string req, input logic [OFS_W-1:0] act,
                         input logic [OFS_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: offset_o=%0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_frame(input logic [1:0] m, input logic [ERR_W-1:0] s,
                               input logic [ERR_W-1:0] md, input logic [OFS_W-1:0] q);
        @(negedge clk);
        slope_mode_i  = m;
        step_i        = s;
        modulo_i      = md;
        nq_i          = q;
        frame_start_i = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
    endtask

    task automatic run_lines(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eol_i = 1'b1;
            @(negedge clk);
            eol_i = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1 reset", offset_o, '0);
        rst = 1'b0;

        for (int v = 0; v < 8; v++) begin
            start_frame(VECS[v].mode, VECS[v].step, VECS[v].modv, VECS[v].nq);
            check("R1 frame start", offset_o, '0);
            run_lines(int'(VECS[v].lines));
            check("R3/R4/R5/R6/R7 vector", offset_o, VECS[v].expect_ofs);
        end

        // R2: no strobe, no change
        start_frame(2'b01, 8'd1, 8'd1, 11'd10);
        run_lines(3);
        repeat (6) @(negedge clk);
        check("R2 idle stable", offset_o, 11'd3);

        // R3: first carry on second line for 15/26
        start_frame(2'b01, 8'd15, 8'd26, 11'd40);
        run_lines(1);
        check("R3 no carry line1", offset_o, 11'd0);
        run_lines(1);
        check("R3 carry line2", offset_o, 11'd1);

        // R1: frame start wins over coincident eol, error cleared too
        @(negedge clk);
        frame_start_i = 1'b1;
        eol_i         = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
        eol_i         = 1'b0;
        check("R1 priority", offset_o, 11'd0);
        run_lines(1);
        check("R1 error cleared", offset_o, 11'd0);

        // R5: vertical mode freezes accumulator (err 15 kept, next fall line carries)
        start_frame(2'b01, 8'd15, 8'd26, 11'd40);
        run_lines(1);
        slope_mode_i = 2'b00;
        run_lines(1);
        check("R5 offset held", offset_o, 11'd0);
        slope_mode_i = 2'b01;
        run_lines(1);
        check("R5 error frozen", offset_o, 11'd1);

        // R7: decrement from zero wraps to nq-1
        start_frame(2'b10, 8'd1, 8'd1, 11'd7);
        run_lines(1);
        check("R7 wrap", offset_o, 11'd6);
        run_lines(1);
        check("R4 rise step", offset_o, 11'd5);

        // R6: increment from nq-1 wraps to zero, R8 in range
        start_frame(2'b01, 8'd1, 8'd1, 11'd3);
        run_lines(2);
        check("R8 top of range", offset_o, 11'd2);
        run_lines(1);
        check("R6 wrap", offset_o, 11'd0);

        // R1: synchronous reset mid-run
        run_lines(1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset", offset_o, 11'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule